// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block forms the word a host reads back from a flash-style array while an embedded program or erase runs. A sequencer tells it when an operation starts (program or erase, with the target data bit that program will write), when the operation ends, which sectors are marked for erase, whether erase is suspended and whether the sector-add window is still open. On each read strobe the block returns either the real array word or a status word. The status word carries a polling bit, two toggle bits and a timer flag. A ready output shows whether an algorithm is running.

The toggle bits advance on reads, not on clock edges. A host that reads the same location twice and compares the toggle bits can therefore tell a running operation from a finished one. The second toggle bit advances only for sectors marked for erase. During erase suspend this lets the host find the suspended sectors: reads of other sectors return array data.

Top module: `opstat_gen`

## Requirements
- R1: After reset `ready` is 1, `rd_data` is all zeros and both toggle states are 0.
- R2: `ready` goes to 0 in the cycle after an `op_start` pulse and returns to 1 in the cycle after an `op_done` pulse. `op_done` while idle has no effect.
- R3: `rd_data` is loaded on the clock edge that samples `rd_stb` and holds its value in every cycle with no read strobe.
- R4: A read while idle returns `arr_data` unchanged.
- R5: During program, bit 7 of a status read is the inverse of the data bit latched at `op_start`, and bits 3 and 2 read 0. In every status word, the bits other than 7, 6, 3 and 2 read 0.
- R6: During erase, bit 7 of every status read is 0.
- R7: Bit 6 of the first status read after `op_start` is 0. It inverts on each later status read, except on erase-suspended reads, where it holds.
- R8: During erase, bit 2 inverts on each read whose sector (`rd_sect`) has its bit set in `sect_sel`. It holds on reads of sectors whose bit is clear.
- R9: During erase, bit 3 of a status word reads 1 when `win_open` is 0 and reads 0 while `win_open` is 1.
- R10: In erase suspend, a read of a sector not marked for erase returns `arr_data` and changes neither toggle state. A read of a marked sector returns a status word with bit 6 held and bit 2 inverting.
- R11: After `op_done` the toggle states stay frozen and reads return array data.
- R12: `op_start` while busy restarts the block. It takes the new operation type and data bit and clears both toggle states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_start | input | 1 | Pulse: an embedded operation begins |
| op_is_erase | input | 1 | Type of the starting operation: 1 erase, 0 program |
| prog_bit | input | 1 | Bit 7 of the data being programmed, latched on `op_start` |
| op_done | input | 1 | Pulse: the embedded operation has completed |
| sect_sel | input | NSECT | Sectors marked for erase, one bit per sector |
| erase_susp | input | 1 | Erase is suspended |
| win_open | input | 1 | Sector-add window still open |
| rd_stb | input | 1 | Read strobe |
| rd_sect | input | SW | Sector index of the read address |
| arr_data | input | DW | Array word at the read address |
| rd_data | output | DW | Word returned to the host |
| ready | output | 1 | 1 when no embedded algorithm runs |

## Verification
Every cycle, the assertions check the ready handshake, the polling bit for each operation type, and the timer flag. They also check that each toggle state inverts or holds according to the read's sector and the suspend flag, that reads with no strobe leave the output alone, and that restarts clear the toggles. Some behaviour only the bench scenarios can show: the actual read sequences a host would use, such as the 0/1/0 pattern of bit 6, bit 2 holding across a read of an unmarked sector and then resuming, the change from array data to status when a suspended search reaches a marked sector, and a program restarted over a running erase.

// File: rtl/opstat_pkg.sv
// Shared types and bit positions for the operation status generator.
// Assumes a data word of at least eight bits.
package opstat_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
    localparam int TMR_BIT  = 3;
    localparam int SEL_BIT  = 2;
    localparam int MIN_DW   = 8;
endpackage

// File: rtl/opstat_track.sv
// Operation tracker: holds the busy flag, the operation kind and the
// latched target data bit. A start pulse wins over a done pulse in the
// same cycle. Assumes start and done are single-cycle pulses.
module opstat_track
    import opstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_start,
    input  logic     op_is_erase,
    input  logic     prog_bit,
    input  logic     op_done,
    output logic     busy_q,
    output op_kind_e kind_q,
    output logic     pbit_q
);

    // Busy flag: set on start, cleared on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (op_start) begin
            busy_q <= 1'b1;
        end else if (op_done) begin
            busy_q <= 1'b0;
        end
    end

    // Operation kind and target bit, captured at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROG;
            pbit_q <= 1'b0;
        end else if (op_start) begin
            kind_q <= op_is_erase ? OP_ERASE : OP_PROG;
            pbit_q <= prog_bit;
        end
    end

endmodule

// File: rtl/opstat_sel.sv
// Sector hit decode: reports whether the read sector is marked for erase.
// Assumes indices at or beyond NSECT never hit.
module opstat_sel #(
    parameter int NSECT = 16,
    parameter int SW    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic [NSECT-1:0] sect_sel,
    input  logic [SW-1:0]    rd_sect,
    output logic             sel_hit
);

    logic [NSECT-1:0] match;

    // One comparator per sector, gated by that sector's select bit.
    for (genvar g = 0; g < NSECT; g++) begin : g_cmp
        assign match[g] = sect_sel[g] && (rd_sect == SW'(g));
    end

    // Any match is a hit.
    assign sel_hit = |match;

endmodule

// File: rtl/opstat_toggle.sv
// Toggle state pair: the read-driven toggle and the sector-limited toggle.
// Clear wins over advance. Assumes advance pulses last one cycle per read.
module opstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv_any,
    input  logic adv_sel,
    output logic tgl_any_q,
    output logic tgl_sel_q
);

    // Read-driven toggle: flips once per qualifying read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tgl_any_q <= 1'b0;
        end else if (adv_any) begin
            tgl_any_q <= ~tgl_any_q;
        end
    end

    // Sector-limited toggle: flips only on reads of marked sectors.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tgl_sel_q <= 1'b0;
        end else if (adv_sel) begin
            tgl_sel_q <= ~tgl_sel_q;
        end
    end

endmodule

// File: rtl/opstat_word.sv
// Read word former: picks array data or a status word on each strobe,
// registers it, and asks the toggle unit to advance. Status words show
// toggle values from before the read. Assumes DW >= MIN_DW.
module opstat_word
    import opstat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          busy,
    input  logic          is_erase,
    input  logic          pbit,
    input  logic          tgl_any,
    input  logic          tgl_sel,
    input  logic          sel_hit,
    input  logic          erase_susp,
    input  logic          win_open,
    input  logic [DW-1:0] arr_data,
    output logic          adv_any,
    output logic          adv_sel,
    output logic [DW-1:0] rd_q
);

    logic          susp_erase;
    logic          status_rd;
    logic [DW-1:0] status_w;

    // Read classification and toggle advance requests.
    always_comb begin
        susp_erase = is_erase && erase_susp;
        status_rd  = rd_stb && busy && !(susp_erase && !sel_hit);
        adv_any    = rd_stb && busy && !susp_erase;
        adv_sel    = rd_stb && busy && is_erase && sel_hit;
    end

    // Status word assembly; unused bits read zero.
    always_comb begin
        status_w           = '0;
        status_w[POLL_BIT] = is_erase ? 1'b0 : ~pbit;
        status_w[TGL_BIT]  = tgl_any;
        status_w[TMR_BIT]  = is_erase && !win_open;
        status_w[SEL_BIT]  = tgl_sel;
    end

    // Output register: loads only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (status_rd) begin
            rd_q <= status_w;
        end else if (rd_stb) begin
            rd_q <= arr_data;
        end
    end

endmodule

// File: rtl/opstat_gen.sv
// Top of the operation status generator. It joins the tracker, sector
// decode, toggle pair and word former. Assumes the sequencer gives
// single-cycle start and done pulses and holds the sector mask steady
// between reads.
module opstat_gen
    import opstat_pkg::*;
#(
    parameter int NSECT = 16,
    parameter int DW    = 8,
    localparam int SW   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_is_erase,
    input  logic             prog_bit,
    input  logic             op_done,
    input  logic [NSECT-1:0] sect_sel,
    input  logic             erase_susp,
    input  logic             win_open,
    input  logic             rd_stb,
    input  logic [SW-1:0]    rd_sect,
    input  logic [DW-1:0]    arr_data,
    output logic [DW-1:0]    rd_data,
    output logic             ready
);

    logic     busy_q;
    op_kind_e kind_q;
    logic     pbit_q;
    logic     is_erase;
    logic     sel_hit;
    logic     adv_any;
    logic     adv_sel;
    logic     t6_q;
    logic     t2_q;

    // Data word must hold every status bit position.
    if (DW < MIN_DW) begin : g_bad_dw
        initial $error("opstat_gen: DW below minimum");
    end

    opstat_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .op_is_erase (op_is_erase),
        .prog_bit    (prog_bit),
        .op_done     (op_done),
        .busy_q      (busy_q),
        .kind_q      (kind_q),
        .pbit_q      (pbit_q)
    );

    // Kind flattened for the word former and checker.
    assign is_erase = (kind_q == OP_ERASE);

    opstat_sel #(.NSECT(NSECT), .SW(SW)) u_sel (
        .sect_sel (sect_sel),
        .rd_sect  (rd_sect),
        .sel_hit  (sel_hit)
    );

    opstat_toggle u_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (op_start),
        .adv_any   (adv_any),
        .adv_sel   (adv_sel),
        .tgl_any_q (t6_q),
        .tgl_sel_q (t2_q)
    );

    opstat_word #(.DW(DW)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .busy       (busy_q),
        .is_erase   (is_erase),
        .pbit       (pbit_q),
        .tgl_any    (t6_q),
        .tgl_sel    (t2_q),
        .sel_hit    (sel_hit),
        .erase_susp (erase_susp),
        .win_open   (win_open),
        .arr_data   (arr_data),
        .adv_any    (adv_any),
        .adv_sel    (adv_sel),
        .rd_q       (rd_data)
    );

    // Ready is the inverse of the registered busy flag.
    assign ready = !busy_q;

endmodule

// File: rtl/opstat_chk.sv
// Property checker for opstat_gen, attached by bind. It watches ports and
// the tracker/toggle state and drives nothing.
module opstat_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic          op_is_erase,
    input logic          prog_bit,
    input logic          op_done,
    input logic          erase_susp,
    input logic          win_open,
    input logic          rd_stb,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] rd_data,
    input logic          ready,
    input logic          busy,
    input logic          is_erase,
    input logic          pbit,
    input logic          sel_hit,
    input logic          t6,
    input logic          t2
);

    logic status_rd;
    assign status_rd = rd_stb && busy && !(is_erase && erase_susp && !sel_hit);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !ready);
    p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && !op_start |=> ready);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    p_idle_array_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && ready |=> rd_data == $past(arr_data));
    p_prog_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && !is_erase |=> rd_data[7] == !$past(pbit) && !rd_data[3] && !rd_data[2]);
    p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && is_erase |=> !rd_data[7]);
    p_tgl_show_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> rd_data[6] == $past(t6));
    p_tgl_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && !(is_erase && erase_susp) && !op_start |=> t6 != $past(t6));
    p_tgl_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !t6 && !t2);
    p_dq2_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && is_erase && sel_hit && !op_start |=> t2 != $past(t2));
    p_dq2_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !sel_hit && !op_start |=> $stable(t2));
    p_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && is_erase |=> rd_data[3] == !$past(win_open));
    p_susp_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && is_erase && erase_susp && !sel_hit && !op_start
        |=> rd_data == $past(arr_data) && $stable(t6) && $stable(t2));
    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !op_start |=> $stable(t6) && $stable(t2));
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> busy && pbit == $past(prog_bit) && is_erase == $past(op_is_erase));

endmodule

bind opstat_gen opstat_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_start    (op_start),
    .op_is_erase (op_is_erase),
    .prog_bit    (prog_bit),
    .op_done     (op_done),
    .erase_susp  (erase_susp),
    .win_open    (win_open),
    .rd_stb      (rd_stb),
    .arr_data    (arr_data),
    .rd_data     (rd_data),
    .ready       (ready),
    .busy        (busy_q),
    .is_erase    (is_erase),
    .pbit        (pbit_q),
    .sel_hit     (sel_hit),
    .t6          (t6_q),
    .t2          (t2_q)
);

// File: tb/tb_opstat_gen.sv
module tb_opstat_gen;
    localparam int NSECT = 16;
    localparam int DW    = 8;
    localparam int SW    = $clog2(NSECT);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_start = 1'b0, op_is_erase = 1'b0, prog_bit = 1'b0, op_done = 1'b0;
    logic [NSECT-1:0] sect_sel = '0;
    logic             erase_susp = 1'b0, win_open = 1'b0, rd_stb = 1'b0;
    logic [SW-1:0]    rd_sect = '0;
    logic [DW-1:0]    arr_data = '0;
    logic [DW-1:0]    rd_data;
    logic             ready;

    int checks = 0;
    int errors = 0;

    // Behavioural model state
    bit    m_busy, m_erase, m_pbit, m_t6, m_t2;
    int    m_data;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    opstat_gen #(.NSECT(NSECT), .DW(DW)) dut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: update model from the applied inputs, advance, compare.
    task automatic step();
        bit sel;
        int w;
        sel = (int'(rd_sect) < NSECT) && sect_sel[rd_sect];
        if (!rst_n) begin
            m_busy = 0; m_erase = 0; m_pbit = 0; m_t6 = 0; m_t2 = 0; m_data = 0; m_tag = "R1";
        end else begin
            if (rd_stb) begin
                if (!m_busy) begin
                    m_data = arr_data; m_tag = "R4";
                end else if (m_erase && erase_susp && !sel) begin
                    m_data = arr_data; m_tag = "R10";
                end else begin
                    w = 0;
                    if (!m_erase && !m_pbit) w += 128;
                    if (m_t6) w += 64;
                    if (m_erase && !win_open) w += 8;
                    if (m_t2) w += 4;
                    m_data = w; m_tag = "R7";
                    if (!(m_erase && erase_susp)) m_t6 = !m_t6;
                    if (m_erase && sel) m_t2 = !m_t2;
                end
            end else begin
                m_tag = "R3";
            end
            if (op_start) begin
                m_busy = 1; m_erase = op_is_erase; m_pbit = prog_bit; m_t6 = 0; m_t2 = 0;
            end else if (op_done) begin
                m_busy = 0;
            end
        end
        @(posedge clk);
        #1;
        chk({m_tag, " rd_data"}, int'(rd_data), m_data);
        chk("R2 ready", int'(ready), int'(!m_busy));
        rd_stb = 0; op_start = 0; op_done = 0;
    endtask

    task automatic rd(int sect, int arr);
        rd_stb = 1; rd_sect = SW'(sect); arr_data = DW'(arr);
        step();
    endtask

    task automatic start(bit er, bit pb);
        op_start = 1; op_is_erase = er; prog_bit = pb;
        step();
    endtask

    task automatic finish_op();
        op_done = 1;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        repeat (3) step();
        rst_n = 1;
        chk("R1 ready after reset", int'(ready), 1);
        chk("R1 rd_data after reset", int'(rd_data), 0);
        step();

        // R4: idle read returns array data
        rd(1, 8'hA5);
        chk("R4 idle read", int'(rd_data), 8'hA5);
        // R3: output holds without a strobe
        arr_data = 8'h11; step(); step();
        chk("R3 hold", int'(rd_data), 8'hA5);
        // R2: done while idle ignored
        finish_op();
        chk("R2 idle done", int'(ready), 1);

        // R5/R7: program with target bit 1
        start(0, 1);
        chk("R2 busy after start", int'(ready), 0);
        rd(0, 8'hFF); chk("R5 R7 first program read", int'(rd_data), 8'h00);
        rd(0, 8'hFF); chk("R7 second read", int'(rd_data), 8'h40);
        rd(0, 8'hFF); chk("R7 third read", int'(rd_data), 8'h00);
        finish_op();
        chk("R2 ready after done", int'(ready), 1);
        rd(0, 8'h5A); chk("R11 array after done", int'(rd_data), 8'h5A);

        // R6/R8/R9: erase of sectors 2 and 5
        sect_sel = 16'h0024; win_open = 1;
        start(1, 0);
        rd(2, 8'hFF); chk("R6 R9 erase sel read", int'(rd_data), 8'h00);
        rd(3, 8'hFF); chk("R8 unsel read holds dq2", int'(rd_data), 8'h44);
        win_open = 0;
        rd(5, 8'hFF); chk("R9 timer closed", int'(rd_data), 8'h0C);

        // R10: erase suspend
        erase_susp = 1;
        rd(3, 8'h3C); chk("R10 unsel sector array", int'(rd_data), 8'h3C);
        rd(2, 8'hFF); chk("R10 sel dq6 held", int'(rd_data), 8'h48);
        rd(2, 8'hFF); chk("R10 sel dq2 toggles", int'(rd_data), 8'h4C);
        erase_susp = 0;

        // R12: restart as program with target bit 0
        start(0, 0);
        rd(7, 8'hFF); chk("R12 restart first read", int'(rd_data), 8'h80);
        rd(7, 8'hFF); chk("R12 restart second read", int'(rd_data), 8'hC0);
        finish_op();
        rd(9, 8'h77); chk("R11 frozen array", int'(rd_data), 8'h77);

        // R7: a new erase starts its toggles from zero again
        win_open = 1;
        start(1, 1);
        rd(5, 8'hFF); chk("R7 fresh op dq6/dq2", int'(rd_data), 8'h00);
        finish_op();
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule